// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Interface

This block is the host-facing register bank of a two-channel serial controller. Each channel has a control port and a data port, and both ports carry an 8-bit bus. Register 0 (the command register) and the two data-port registers can be reached directly. Every other register takes two steps. The host first writes the register's index into the command register through the control port. Its next control-port access then lands on the register it pointed at, and the pointer falls back to zero.

The block stores both channels' write registers and drives their contents to the serial engines on two flat configuration buses. It also assembles read data from stored values and from live status inputs. That covers a hidden option register that shares an index with register 7, two registers that both channels share, registers whose read-back depends on the channel, and read aliases that depend on one option bit. Command fields, reset fields and recovered-clock fields are decoded into one-cycle strobes and are never stored. A host access that arrives before the recovery gap since the last accepted access has elapsed is flagged and dropped.

Top module: `sercom_regfile`

## Requirements
- R1: After reset all stored registers, `rdata`, all strobes and both pointers are zero, and the first host access is accepted.
- R2: A control-port write while the channel's pointer is zero sets that channel's pointer. The pointer becomes `wdata[2:0]`, or `wdata[2:0]` plus 8 when `wdata[5:3]` = 001. The channel's next control-port access targets that register, and any control-port access with a non-zero pointer returns the pointer to zero.
- R3: A command-register write raises `cmd_stb` for one cycle when `wdata[5:3]` is 010 to 111 or `wdata[7:6]` is not 00. `cmd_code` = `wdata[5:3]` and `crc_code` = `wdata[7:6]`.
- R4: Write registers 1, 3 to 6, 10 to 13 and 15 are stored separately for each channel. They appear in byte slot n of `cfg_a`/`cfg_b` (bits n*8+7:n*8). Reads of index 12, 13 and 15 always return the stored value.
- R5: A write to index 7 goes to register 7 when bit 0 of the channel's register 15 is 0, and to the option register when that bit is 1. The option register appears in byte slot 8 of the configuration bus.
- R6: Register 2 (vector) and register 9 (master control) are single copies shared by both channels and appear in slots 2 and 9 of both configuration buses. A control read of index 2 on channel A returns the stored vector.
- R7: In a register-9 write, `wdata[7:6]` is a reset command (01 channel A, 10 channel B, 11 hardware). A non-zero code pulses `rst_stb` with `rst_code`. Only bits 5:0 are stored.
- R8: In a register-14 write, a non-zero `wdata[7:5]` pulses `dpll_stb` with `dpll_cmd`. Only bits 4:0 are stored.
- R9: A control read of index 3 returns `{2'b00, ipend}` on channel A and 0 on channel B.
- R10: A control read of index 2 on channel B returns `vec_live`.
- R11: When bit 6 of the channel's option register is 1, reads of index 4, 5, 9 and 11 return write registers 4, 5, 3 and 10. Otherwise they return 0.
- R12: A data-port write pulses `tx_stb` with `tx_byte`, and a data-port read returns the channel's receive byte. A control access with the pointer at 8 does the same. Data-port accesses leave the pointer unchanged.
- R13: An access that comes fewer than `GAP_CYC` cycles after the last accepted access is ignored and raises `gap_err` for one cycle. An access exactly `GAP_CYC` cycles later is accepted.
- R14: Control reads of index 0, 1 and 10 return the channel's live status bytes. Index 6, 7 and 14 read as 0. All results appear on `rdata` one cycle after the access and hold until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select |
| chan | input | 1 | Channel select, 0 = A, 1 = B |
| data_port | input | 1 | 1 = data port, 0 = control port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (takes priority over rd) |
| wdata | input | 8 | Write data |
| rr0_a | input | 8 | Channel A live status 0 |
| rr0_b | input | 8 | Channel B live status 0 |
| rr1_a | input | 8 | Channel A live status 1 |
| rr1_b | input | 8 | Channel B live status 1 |
| rr10_a | input | 8 | Channel A live status 10 |
| rr10_b | input | 8 | Channel B live status 10 |
| rxd_a | input | 8 | Channel A receive byte |
| rxd_b | input | 8 | Channel B receive byte |
| vec_live | input | 8 | Vector with status |
| ipend | input | 6 | Interrupt pending bits |
| rdata | output | 8 | Registered read data |
| ev_chan | output | 1 | Channel of the last accepted access |
| tx_stb | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| cmd_stb | output | 1 | Command strobe |
| cmd_code | output | 3 | Command code |
| crc_code | output | 2 | CRC/underrun reset code |
| rst_stb | output | 1 | Reset command strobe |
| rst_code | output | 2 | Reset command code |
| dpll_stb | output | 1 | Recovered-clock command strobe |
| dpll_cmd | output | 3 | Recovered-clock command |
| gap_err | output | 1 | Recovery-gap violation pulse |
| cfg_a | output | 128 | Channel A register image, slot n at bits n*8+7:n*8 |
| cfg_b | output | 128 | Channel B register image |

## Verification
The bench targets three kinds of mistake.

The first is index-7 steering. A design that ignored the select bit in register 15 would overwrite register 7 when the option register was meant, and the option slot would never change. A design that kept a separate copy of register 2 or 9 for each channel would show a stale value in the other channel's image.

The second is the reset and clock-command bits. If these leaked into storage, the images would hold high bits that the bench expects to be clear. If the extended read bit were mishandled, reads of 4, 5, 9 and 11 would return the wrong register or a non-zero value.

The third is pointer and timing behaviour. A design that left the pointer set after an access, or moved it on a data-port access, would return the wrong byte on the following control read. A write issued one cycle after another must vanish and raise the error pulse, so a design without the gap check would produce a command strobe that the bench does not expect.

// File: rtl/sercom_regfile.sv
module sercom_regfile #(
  parameter int GAP_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         chan,
  input  logic         data_port,
  input  logic         rd,
  input  logic         wr,
  input  logic [7:0]   wdata,
  input  logic [7:0]   rr0_a,
  input  logic [7:0]   rr0_b,
  input  logic [7:0]   rr1_a,
  input  logic [7:0]   rr1_b,
  input  logic [7:0]   rr10_a,
  input  logic [7:0]   rr10_b,
  input  logic [7:0]   rxd_a,
  input  logic [7:0]   rxd_b,
  input  logic [7:0]   vec_live,
  input  logic [5:0]   ipend,
  output logic [7:0]   rdata,
  output logic         ev_chan,
  output logic         tx_stb,
  output logic [7:0]   tx_byte,
  output logic         cmd_stb,
  output logic [2:0]   cmd_code,
  output logic [1:0]   crc_code,
  output logic         rst_stb,
  output logic [1:0]   rst_code,
  output logic         dpll_stb,
  output logic [2:0]   dpll_cmd,
  output logic         gap_err,
  output logic [127:0] cfg_a,
  output logic [127:0] cfg_b
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] GAP = CW'(GAP_CYC);

  logic [CW-1:0] gcnt;
  logic [3:0]    ptr [2];
  logic [7:0]    wreg [2][16];
  logic [7:0]    opt [2];
  logic [7:0]    vec;
  logic [5:0]    mic;
  logic [7:0]    rd_val;

  wire       acc     = sel && (rd || wr);
  wire       ok      = acc && (gcnt == GAP);
  wire [3:0] cur     = ptr[chan];
  wire       ext     = opt[chan][6];
  wire       opt_sel = wreg[chan][15][0];
  wire [7:0] rxd     = chan ? rxd_b : rxd_a;
  wire [3:0] ptr_nx  = {wdata[5:3] == 3'b001, wdata[2:0]};

  always_comb begin
    rd_val = 8'h00;
    if (data_port) rd_val = rxd;
    else case (cur)
      4'd0:  rd_val = chan ? rr0_b : rr0_a;
      4'd1:  rd_val = chan ? rr1_b : rr1_a;
      4'd2:  rd_val = chan ? vec_live : vec;
      4'd3:  rd_val = chan ? 8'h00 : {2'b00, ipend};
      4'd4:  rd_val = ext ? wreg[chan][4] : 8'h00;
      4'd5:  rd_val = ext ? wreg[chan][5] : 8'h00;
      4'd8:  rd_val = rxd;
      4'd9:  rd_val = ext ? wreg[chan][3] : 8'h00;
      4'd10: rd_val = chan ? rr10_b : rr10_a;
      4'd11: rd_val = ext ? wreg[chan][10] : 8'h00;
      4'd12, 4'd13, 4'd15: rd_val = wreg[chan][cur];
      default: rd_val = 8'h00;
    endcase
  end

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      cfg_a[i*8 +: 8] = wreg[0][i];
      cfg_b[i*8 +: 8] = wreg[1][i];
    end
    cfg_a[2*8 +: 8] = vec;          cfg_b[2*8 +: 8] = vec;
    cfg_a[8*8 +: 8] = opt[0];       cfg_b[8*8 +: 8] = opt[1];
    cfg_a[9*8 +: 8] = {2'b00, mic}; cfg_b[9*8 +: 8] = {2'b00, mic};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt <= GAP;
      for (int c = 0; c < 2; c++) begin
        ptr[c] <= '0;
        opt[c] <= '0;
        for (int i = 0; i < 16; i++) wreg[c][i] <= '0;
      end
      vec <= '0; mic <= '0; rdata <= '0; ev_chan <= 1'b0;
      tx_stb <= 1'b0; tx_byte <= '0; cmd_stb <= 1'b0; cmd_code <= '0; crc_code <= '0;
      rst_stb <= 1'b0; rst_code <= '0; dpll_stb <= 1'b0; dpll_cmd <= '0; gap_err <= 1'b0;
    end else begin
      tx_stb <= 1'b0; cmd_stb <= 1'b0; rst_stb <= 1'b0; dpll_stb <= 1'b0;
      gap_err <= acc && !ok;
      if (ok) gcnt <= CW'(1);
      else if (gcnt != GAP) gcnt <= gcnt + CW'(1);
      if (ok) begin
        ev_chan <= chan;
        if (!wr) rdata <= rd_val;
        if (data_port) begin
          if (wr) begin tx_stb <= 1'b1; tx_byte <= wdata; end
        end else if (cur == 4'd0) begin
          if (wr) begin
            ptr[chan] <= ptr_nx;
            cmd_stb   <= (wdata[5:3] >= 3'd2) || (wdata[7:6] != 2'b00);
            cmd_code  <= wdata[5:3];
            crc_code  <= wdata[7:6];
          end
        end else begin
          ptr[chan] <= '0;
          if (wr) case (cur)
            4'd2: vec <= wdata;
            4'd7: if (opt_sel) opt[chan] <= wdata; else wreg[chan][7] <= wdata;
            4'd8: begin tx_stb <= 1'b1; tx_byte <= wdata; end
            4'd9: begin
              mic <= wdata[5:0];
              rst_stb <= wdata[7:6] != 2'b00;
              rst_code <= wdata[7:6];
            end
            4'd14: begin
              wreg[chan][14] <= {3'b000, wdata[4:0]};
              dpll_stb <= wdata[7:5] != 3'b000;
              dpll_cmd <= wdata[7:5];
            end
            default: wreg[chan][cur] <= wdata;
          endcase
        end
      end
    end
  end

  p_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> !(tx_stb || cmd_stb || rst_stb || dpll_stb));
  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !data_port && cur != 4'd0) |=> ptr[$past(chan)] == 4'd0);
  p_data_ptr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && data_port) |=> $stable(ptr[0]) && $stable(ptr[1]));
  p_rst_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |-> rst_code != 2'b00 && cfg_a[79:78] == 2'b00);
  p_dpll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_stb |-> dpll_cmd != 3'b000 && cfg_a[119:117] == 3'b000 && cfg_b[119:117] == 3'b000);
  p_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cmd_code >= 3'd2 || crc_code != 2'b00));
  p_rdhold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && !wr) |=> $stable(rdata));
  p_rr3b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !wr && chan && !data_port && cur == 4'd3) |=> rdata == 8'h00);
endmodule

// File: tb/sim_sercom_regfile.sv
module sim_sercom_regfile;
  localparam int CLK_PER = 10;
  localparam int GAP = 4;

  logic clk = 0, rst_n = 0, sel = 0, chan = 0, data_port = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] l0 [2], l1 [2], l10 [2], rx [2];
  logic [7:0] vec_live;
  logic [5:0] ipend;
  logic [7:0] rdata, tx_byte;
  logic ev_chan, tx_stb, cmd_stb, rst_stb, dpll_stb, gap_err;
  logic [2:0] cmd_code, dpll_cmd;
  logic [1:0] crc_code, rst_code;
  logic [127:0] cfg_a, cfg_b;

  sercom_regfile #(.GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .chan(chan), .data_port(data_port), .rd(rd), .wr(wr),
    .wdata(wdata), .rr0_a(l0[0]), .rr0_b(l0[1]), .rr1_a(l1[0]), .rr1_b(l1[1]),
    .rr10_a(l10[0]), .rr10_b(l10[1]), .rxd_a(rx[0]), .rxd_b(rx[1]), .vec_live(vec_live),
    .ipend(ipend), .rdata(rdata), .ev_chan(ev_chan), .tx_stb(tx_stb), .tx_byte(tx_byte),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .crc_code(crc_code), .rst_stb(rst_stb),
    .rst_code(rst_code), .dpll_stb(dpll_stb), .dpll_cmd(dpll_cmd), .gap_err(gap_err),
    .cfg_a(cfg_a), .cfg_b(cfg_b));

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_wr [2][16];
  logic [7:0] m_opt [2];
  logic [7:0] m_vec;
  logic [5:0] m_mic;
  logic [7:0] c_rdata, c_tx_byte;
  logic c_tx, c_cmd, c_rst, c_dpll, c_gap;
  logic [2:0] c_cmd_code, c_dpll_cmd;
  logic [1:0] c_crc, c_rst_code;

  task automatic chk(input bit cond, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    c_rdata = rdata; c_tx = tx_stb; c_tx_byte = tx_byte; c_cmd = cmd_stb; c_cmd_code = cmd_code;
    c_crc = crc_code; c_rst = rst_stb; c_rst_code = rst_code; c_dpll = dpll_stb;
    c_dpll_cmd = dpll_cmd; c_gap = gap_err;
  endtask

  task automatic bus(input bit c, input bit dp, input bit w, input logic [7:0] d);
    @(negedge clk);
    sel = 1; chan = c; data_port = dp; wr = w; rd = !w; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0; rd = 0;
    capture();
    repeat (GAP - 2) @(negedge clk);
  endtask

  function automatic logic [7:0] pbyte(input int idx);
    return idx < 8 ? 8'(idx) : (8'h08 | 8'(idx & 7));
  endfunction

  function automatic void m_write(input bit c, input int idx, input logic [7:0] v);
    case (idx)
      2: m_vec = v;
      7: if (m_wr[c][15][0]) m_opt[c] = v; else m_wr[c][7] = v;
      8: ;
      9: m_mic = v[5:0];
      14: m_wr[c][14] = {3'b000, v[4:0]};
      default: m_wr[c][idx] = v;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input bit c, input int idx);
    bit e = m_opt[c][6];
    case (idx)
      0: return l0[c];
      1: return l1[c];
      2: return c ? vec_live : m_vec;
      3: return c ? 8'h00 : {2'b00, ipend};
      4: return e ? m_wr[c][4] : 8'h00;
      5: return e ? m_wr[c][5] : 8'h00;
      8: return rx[c];
      9: return e ? m_wr[c][3] : 8'h00;
      10: return l10[c];
      11: return e ? m_wr[c][10] : 8'h00;
      12, 13, 15: return m_wr[c][idx];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [127:0] exp_cfg(input bit c);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = m_wr[c][i];
    r[7:0] = 8'h00;
    r[2*8 +: 8] = m_vec;
    r[8*8 +: 8] = m_opt[c];
    r[9*8 +: 8] = {2'b00, m_mic};
    return r;
  endfunction

  task automatic wreg(input bit c, input int idx, input logic [7:0] v);
    if (idx != 0) bus(c, 0, 1, pbyte(idx));
    bus(c, 0, 1, v);
    m_write(c, idx, v);
  endtask

  task automatic rreg(input bit c, input int idx, input string tag);
    if (idx != 0) bus(c, 0, 1, pbyte(idx));
    bus(c, 0, 0, 8'h00);
    chk(c_rdata == exp_read(c, idx), tag, c_rdata, exp_read(c, idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 2; c++) begin
      l0[c] = 8'($urandom); l1[c] = 8'($urandom); l10[c] = 8'($urandom); rx[c] = 8'($urandom);
      m_opt[c] = 0;
      for (int i = 0; i < 16; i++) m_wr[c][i] = 0;
    end
    vec_live = 8'($urandom); ipend = 6'($urandom); m_vec = 0; m_mic = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdata == 0 && !tx_stb && !cmd_stb && !rst_stb && !dpll_stb && !gap_err, "R1 reset outputs", rdata, 0);
    chk(cfg_a == 0 && cfg_b == 0, "R1 reset images", cfg_a | cfg_b, 0);
    rreg(0, 0, "R1 R14 first access read RR0");
    chk(!c_gap, "R1 first access accepted", c_gap, 0);

    bus(0, 0, 1, 8'h10);
    chk(c_cmd && c_cmd_code == 3'd2 && c_crc == 0, "R3 ext status reset", {c_cmd, c_cmd_code, c_crc}, {1'b1, 3'd2, 2'd0});
    bus(1, 0, 1, 8'hC0);
    chk(c_cmd && c_crc == 2'd3 && c_cmd_code == 0, "R3 underrun reset", {c_cmd, c_crc}, {1'b1, 2'd3});
    bus(1, 0, 1, 8'h38);
    chk(c_cmd && c_cmd_code == 3'd7, "R3 highest in-service reset", c_cmd_code, 7);

    bus(0, 0, 1, pbyte(12));
    chk(!c_cmd, "R3 point-high has no strobe", c_cmd, 0);
    bus(0, 1, 1, 8'h5A);
    chk(c_tx && c_tx_byte == 8'h5A, "R12 data port tx", c_tx_byte, 8'h5A);
    bus(0, 0, 1, 8'h77); m_write(0, 12, 8'h77);
    chk(!c_cmd && !c_tx, "R12 pointer kept across data write", c_cmd, 0);
    rreg(0, 12, "R2 R4 pointed write lands");
    rreg(0, 0, "R2 pointer back to zero");
    bus(1, 1, 0, 8'h00);
    chk(c_rdata == rx[1], "R12 data port rx", c_rdata, rx[1]);
    rreg(1, 8, "R12 control read of index 8");
    wreg(1, 8, 8'hA3);
    chk(c_tx && c_tx_byte == 8'hA3, "R12 control write of index 8", c_tx_byte, 8'hA3);

    wreg(1, 9, 8'hC5);
    chk(c_rst && c_rst_code == 2'd3, "R7 hardware reset strobe", c_rst_code, 3);
    chk(cfg_a == exp_cfg(0) && cfg_b == exp_cfg(1), "R6 R7 shared reg9 low bits", cfg_a, exp_cfg(0));
    wreg(0, 9, 8'h40);
    chk(c_rst && c_rst_code == 2'd1, "R7 channel A reset", c_rst_code, 1);
    wreg(0, 9, 8'h0A);
    chk(!c_rst, "R7 no reset code no strobe", c_rst, 0);
    wreg(0, 14, 8'hFF);
    chk(c_dpll && c_dpll_cmd == 3'd7, "R8 nrzi command", c_dpll_cmd, 7);
    chk(cfg_a[14*8 +: 8] == 8'h1F, "R8 only low bits stored", cfg_a[14*8 +: 8], 8'h1F);
    wreg(1, 14, 8'h0C);
    chk(!c_dpll && cfg_b[14*8 +: 8] == 8'h0C, "R8 no command", cfg_b[14*8 +: 8], 8'h0C);

    wreg(1, 2, 8'h9E);
    chk(cfg_a[2*8 +: 8] == 8'h9E, "R6 vector shared", cfg_a[2*8 +: 8], 8'h9E);
    rreg(0, 2, "R6 vector read on A");
    rreg(1, 2, "R10 vector with status on B");
    rreg(0, 3, "R9 pending on A");
    rreg(1, 3, "R9 pending zero on B");

    wreg(0, 7, 8'h11);
    wreg(0, 15, 8'h01);
    wreg(0, 7, 8'hAA);
    chk(cfg_a[8*8 +: 8] == 8'hAA && cfg_a[7*8 +: 8] == 8'h11, "R5 option selected", cfg_a[71:56], 16'hAA11);
    wreg(0, 15, 8'h00);
    wreg(0, 7, 8'h33);
    chk(cfg_a[8*8 +: 8] == 8'hAA && cfg_a[7*8 +: 8] == 8'h33, "R5 normal selected", cfg_a[71:56], 16'hAA33);

    wreg(1, 4, 8'h44); wreg(1, 5, 8'h55); wreg(1, 3, 8'h33); wreg(1, 10, 8'hA0);
    rreg(1, 4, "R11 alias off reads zero");
    wreg(1, 15, 8'h01); wreg(1, 7, 8'h40);
    rreg(1, 4, "R11 alias 4");
    rreg(1, 5, "R11 alias 5");
    rreg(1, 9, "R11 alias 9 to wr3");
    rreg(1, 11, "R11 alias 11 to wr10");
    rreg(1, 1, "R14 live status 1");
    rreg(1, 10, "R14 live status 10");
    rreg(1, 14, "R14 index 14 reads zero");

    bus(0, 0, 1, pbyte(13));
    @(negedge clk);
    sel = 1; chan = 0; data_port = 0; wr = 1; rd = 0; wdata = 8'h21;
    @(negedge clk);
    wdata = 8'h10;
    @(negedge clk);
    sel = 0; wr = 0;
    capture();
    chk(c_gap && !c_cmd, "R13 early access ignored", {c_gap, c_cmd}, 2'b10);
    m_write(0, 13, 8'h21);
    repeat (GAP) @(negedge clk);
    rreg(0, 13, "R13 only the accepted write landed");

    for (int k = 0; k < 300; k++) begin
      bit c = 1'($urandom);
      int idx = int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) begin
        if (idx != 0) wreg(c, idx, 8'($urandom));
      end else rreg(c, idx, "R4 R11 R14 random read");
      chk(cfg_a == exp_cfg(0) && cfg_b == exp_cfg(1), "R4 R5 R6 random image", c ? cfg_b : cfg_a, exp_cfg(c));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule